// File: doc/BRIEF.md
# Masked Vector-Divide Lane Writeback Controller

This block sits between instruction decode and a bank of per-lane 64-bit divide units. When it accepts an operation, it latches the operand vectors and the control fields. It then drives a dividend and a divisor to every lane that lies inside the active vector length, together with the rounding mode those units must use. Each lane's quotient and exception flags are captured as they arrive on a valid-tagged return port. Once every issued lane has answered, the block builds the destination vector and raises `done` for one cycle. The divide arithmetic itself is outside the block.

Destination assembly applies four rules:
- per-lane write enables from an 8-bit mask;
- either merging (an unwritten lane keeps its old value) or zeroing;
- optional replication of the low 64 bits of the second source as the divisor for every lane;
- one of two policies for the bits above the active length: the legacy encoding keeps them, and the newer encodings clear them.

Exception flags from lanes that are not written are dropped. The rest are ORed into one 6-bit status word.

The controller is a three-state machine:
- `ST_IDLE`: waiting for `start`. The transition *accept* (`start` high) latches the operation and moves to `ST_WAIT`.
- `ST_WAIT`: lanes are issued and returns are collected. The transition *all returned* (every issued lane has delivered a valid quotient) registers the result and moves to `ST_DONE`.
- `ST_DONE`: `done` is high for one cycle. The transition *retire* goes back to `ST_IDLE` unconditionally.

Top module: `vdiv_wb_ctrl`

## Requirements
- R1: The length code `len_sel` selects the number of active 64-bit lanes: 0 gives 2 lanes, 1 gives 4, and 2 or 3 gives 8. While in `ST_WAIT`, `lane_issue` has exactly the bits below that lane count set.
- R2: Lane j occupies bits [64j+63:64j]. For each issued lane, `lane_dividend` carries lane j of `src_a` and `lane_divisor` carries lane j of `src_b`.
- R3: With `enc_class` = 2 (masked), `bcast` = 1 and `b_is_mem` = 1, every issued lane's divisor is `src_b[63:0]`. In every other case `bcast` has no effect.
- R4: With `enc_class` = 2, an active lane is written with its quotient only if its `lane_mask` bit is 1 or `mask_en` is 0. The other encodings (0, 1 and 3) write every active lane and ignore the mask.
- R5: An active lane that is not written takes its `dest_prev` value when `zero_mode` = 0 and becomes all zeros when `zero_mode` = 1.
- R6: For `enc_class` 1, 2 or 3, every `dest_out` bit at or above the active length is zero.
- R7: For `enc_class` = 0 (legacy), the length is 128 bits whatever `len_sel` holds, and `dest_out[511:128]` equals `dest_prev[511:128]`.
- R8: `rm_out` equals `embed_rm` when `enc_class` = 2, the length is 512, `bcast` = 1 and `b_is_mem` = 0. Otherwise it equals `global_rm`. The value stays fixed for the whole operation.
- R9: `status_flags` is the bitwise OR of the 6-bit `quot_flags` of the lanes written with a quotient. It is zero when no lane is written.
- R10: `start` is accepted only in `ST_IDLE`. The operation's inputs are latched at acceptance, so later input changes and `start` pulses during the operation have no effect. `done` is high for exactly one cycle, and it follows the cycle in which the last issued lane's quotient was captured.
- R11: Returns on lanes that are not issued (valid, data and flags) never reach `dest_out` or `status_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to accept an operation |
| enc_class | input | 2 | 0 legacy, 1 three-operand, 2 masked, 3 treated as three-operand |
| len_sel | input | 2 | 0: 128, 1: 256, 2/3: 512 bits |
| src_a | input | 512 | Dividend vector |
| src_b | input | 512 | Divisor vector |
| dest_prev | input | 512 | Prior destination contents |
| lane_mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Mask in use (masked encoding only) |
| zero_mode | input | 1 | 1 zeroes unwritten lanes, 0 merges |
| bcast | input | 1 | Broadcast flag |
| b_is_mem | input | 1 | Second source comes from memory |
| embed_rm | input | 2 | Rounding mode carried by the operation |
| global_rm | input | 2 | Global rounding-mode setting |
| quot_valid | input | 8 | Per-lane quotient valid |
| quot_data | input | 512 | Per-lane quotients |
| quot_flags | input | 48 | Per-lane exception flags, 6 per lane |
| busy | output | 1 | Operation in progress |
| lane_issue | output | 8 | Lanes currently issued to the divide bank |
| lane_dividend | output | 512 | Per-lane dividends |
| lane_divisor | output | 512 | Per-lane divisors |
| rm_out | output | 2 | Rounding mode for the divide bank |
| done | output | 1 | One-cycle completion pulse |
| dest_out | output | 512 | Assembled destination |
| status_flags | output | 6 | ORed exception flags of written lanes |

## Verification
The bench builds the block with its default parameters: 64-bit lanes, eight lanes and 6-bit flags. With these values all three lengths are reachable, so the legacy policy for the upper bits, the zero-clearing policy and full 512-bit broadcast with rounding override can all be exercised against each other.

The bench's divide model answers each lane after its own random delay. It also drives junk returns on lanes that are not issued, which makes out-of-order completion and the ignore rule for unissued lanes visible at the ports. Randomized control fields cover every combination of encoding, mask, merge/zero choice and broadcast choice.

// File: rtl/vdw_pkg.sv
package vdw_pkg;
    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_TRIO   = 2'd1,
        ENC_MASKED = 2'd2,
        ENC_SPARE  = 2'd3
    } enc_e;

    typedef enum logic [1:0] {
        LEN_128 = 2'd0,
        LEN_256 = 2'd1,
        LEN_512 = 2'd2,
        LEN_ALT = 2'd3
    } len_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } st_e;
endpackage

// File: rtl/vdw_mode_decode.sv
module vdw_mode_decode
    import vdw_pkg::*;
#(
    parameter int LANES = 8,
    parameter int RM_W  = 2
) (
    input  logic [1:0]       enc_class,
    input  logic [1:0]       len_sel,
    input  logic [LANES-1:0] lane_mask,
    input  logic             mask_en,
    input  logic             bcast,
    input  logic             b_is_mem,
    input  logic [RM_W-1:0]  embed_rm,
    input  logic [RM_W-1:0]  global_rm,
    output logic [LANES-1:0] act,
    output logic [LANES-1:0] wr,
    output logic             bcast_use,
    output logic             legacy,
    output logic [RM_W-1:0]  rm_sel
);
    enc_e enc;
    logic masked;
    logic full_len;
    int   n_act;

    always_comb begin
        enc      = enc_e'(enc_class);
        legacy   = (enc == ENC_LEGACY);
        masked   = (enc == ENC_MASKED);
        full_len = !legacy && (len_sel[1] == 1'b1);
        if (legacy || len_e'(len_sel) == LEN_128) n_act = 2;
        else if (len_e'(len_sel) == LEN_256)      n_act = 4;
        else                                      n_act = 8;
        if (n_act > LANES) n_act = LANES;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_act
        assign act[j] = (j < n_act);
        assign wr[j]  = act[j] && (!masked || !mask_en || lane_mask[j]);
    end

    assign bcast_use = masked && bcast && b_is_mem;
    assign rm_sel    = (masked && full_len && bcast && !b_is_mem) ? embed_rm : global_rm;
endmodule

// File: rtl/vdw_operand_route.sv
module vdw_operand_route #(
    parameter int LANE_W = 64,
    parameter int LANES  = 8
) (
    input  logic [LANES-1:0]        issue,
    input  logic                    bcast_use,
    input  logic [LANE_W*LANES-1:0] a_vec,
    input  logic [LANE_W*LANES-1:0] b_vec,
    output logic [LANE_W*LANES-1:0] dividend,
    output logic [LANE_W*LANES-1:0] divisor
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] b_pick;
        assign b_pick = bcast_use ? b_vec[LANE_W-1:0] : b_vec[j*LANE_W +: LANE_W];
        assign dividend[j*LANE_W +: LANE_W] = issue[j] ? a_vec[j*LANE_W +: LANE_W] : '0;
        assign divisor[j*LANE_W +: LANE_W]  = issue[j] ? b_pick : '0;
    end
endmodule

// File: rtl/vdw_lane_collect.sv
module vdw_lane_collect #(
    parameter int LANE_W = 64,
    parameter int LANES  = 8,
    parameter int FLAG_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic [LANES-1:0]        act,
    input  logic [LANES-1:0]        issue,
    input  logic [LANES-1:0]        quot_valid,
    input  logic [LANE_W*LANES-1:0] quot_data,
    input  logic [FLAG_W*LANES-1:0] quot_flags,
    output logic [LANE_W*LANES-1:0] q_held,
    output logic [FLAG_W*LANES-1:0] f_held,
    output logic                    all_in
);
    logic [LANES-1:0] got;

    for (genvar j = 0; j < LANES; j++) begin : g_cap
        logic take;
        assign take = issue[j] && quot_valid[j] && !got[j];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                got[j] <= 1'b0;
            end else if (clear) begin
                got[j] <= 1'b0;
            end else if (take) begin
                got[j] <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_held[j*LANE_W +: LANE_W] <= '0;
                f_held[j*FLAG_W +: FLAG_W] <= '0;
            end else if (take) begin
                q_held[j*LANE_W +: LANE_W] <= quot_data[j*LANE_W +: LANE_W];
                f_held[j*FLAG_W +: FLAG_W] <= quot_flags[j*FLAG_W +: FLAG_W];
            end
        end
    end

    assign all_in = ((got & act) == act);

    // R11: a lane outside the issued set never records a return
    a_r11_no_stray_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !issue[0] && !got[0]) |=> !got[0]);
endmodule

// File: rtl/vdw_dest_assemble.sv
module vdw_dest_assemble #(
    parameter int LANE_W = 64,
    parameter int LANES  = 8,
    parameter int FLAG_W = 6
) (
    input  logic [LANES-1:0]        act,
    input  logic [LANES-1:0]        wr,
    input  logic                    zero_mode,
    input  logic                    legacy,
    input  logic [LANE_W*LANES-1:0] prev,
    input  logic [LANE_W*LANES-1:0] q_held,
    input  logic [FLAG_W*LANES-1:0] f_held,
    output logic [LANE_W*LANES-1:0] dest,
    output logic [FLAG_W-1:0]       status
);
    logic [FLAG_W*LANES-1:0] f_gated;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] prev_l;
        logic [LANE_W-1:0] q_l;
        assign prev_l = prev[j*LANE_W +: LANE_W];
        assign q_l    = q_held[j*LANE_W +: LANE_W];

        always_comb begin
            if (!act[j])        dest[j*LANE_W +: LANE_W] = legacy ? prev_l : '0;
            else if (wr[j])     dest[j*LANE_W +: LANE_W] = q_l;
            else if (zero_mode) dest[j*LANE_W +: LANE_W] = '0;
            else                dest[j*LANE_W +: LANE_W] = prev_l;
        end

        assign f_gated[j*FLAG_W +: FLAG_W] = wr[j] ? f_held[j*FLAG_W +: FLAG_W] : '0;
    end

    always_comb begin
        status = '0;
        for (int j = 0; j < LANES; j++) status = status | f_gated[j*FLAG_W +: FLAG_W];
    end

    // R5: a written lane never shows the zero or merge value instead of its quotient
    always_comb begin
        a_r5_written_lane_quotient: assert (!(wr[0] && dest[LANE_W-1:0] != q_held[LANE_W-1:0]));
    end
endmodule

// File: rtl/vdiv_wb_ctrl.sv
module vdiv_wb_ctrl
    import vdw_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int LANES  = 8,
    parameter int FLAG_W = 6,
    parameter int RM_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              enc_class,
    input  logic [1:0]              len_sel,
    input  logic [LANE_W*LANES-1:0] src_a,
    input  logic [LANE_W*LANES-1:0] src_b,
    input  logic [LANE_W*LANES-1:0] dest_prev,
    input  logic [LANES-1:0]        lane_mask,
    input  logic                    mask_en,
    input  logic                    zero_mode,
    input  logic                    bcast,
    input  logic                    b_is_mem,
    input  logic [RM_W-1:0]         embed_rm,
    input  logic [RM_W-1:0]         global_rm,
    input  logic [LANES-1:0]        quot_valid,
    input  logic [LANE_W*LANES-1:0] quot_data,
    input  logic [FLAG_W*LANES-1:0] quot_flags,
    output logic                    busy,
    output logic [LANES-1:0]        lane_issue,
    output logic [LANE_W*LANES-1:0] lane_dividend,
    output logic [LANE_W*LANES-1:0] lane_divisor,
    output logic [RM_W-1:0]         rm_out,
    output logic                    done,
    output logic [LANE_W*LANES-1:0] dest_out,
    output logic [FLAG_W-1:0]       status_flags
);
    localparam int VEC_W = LANE_W * LANES;
    localparam int LOW_W = 2 * LANE_W;

    st_e state, state_nxt;

    logic [LANES-1:0] act_d, wr_d, act_q, wr_q;
    logic             bcast_d, legacy_d, bcast_q, legacy_q, zm_q;
    logic [RM_W-1:0]  rm_d, rm_q;
    logic [VEC_W-1:0] a_q, b_q, prev_q;
    logic [VEC_W-1:0] q_held, dest_c;
    logic [FLAG_W*LANES-1:0] f_held;
    logic [FLAG_W-1:0] status_c;
    logic             accept, all_in;

    vdw_mode_decode #(.LANES(LANES), .RM_W(RM_W)) u_decode (
        .enc_class (enc_class),
        .len_sel   (len_sel),
        .lane_mask (lane_mask),
        .mask_en   (mask_en),
        .bcast     (bcast),
        .b_is_mem  (b_is_mem),
        .embed_rm  (embed_rm),
        .global_rm (global_rm),
        .act       (act_d),
        .wr        (wr_d),
        .bcast_use (bcast_d),
        .legacy    (legacy_d),
        .rm_sel    (rm_d)
    );

    assign accept = (state == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start)  state_nxt = ST_WAIT;
            ST_WAIT: if (all_in) state_nxt = ST_DONE;
            ST_DONE:             state_nxt = ST_IDLE;
            default:             state_nxt = ST_IDLE;
        endcase
    end

    // operation latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0; wr_q <= '0; bcast_q <= 1'b0; legacy_q <= 1'b0;
            zm_q <= 1'b0; rm_q <= '0; a_q <= '0; b_q <= '0; prev_q <= '0;
        end else if (accept) begin
            act_q    <= act_d;
            wr_q     <= wr_d;
            bcast_q  <= bcast_d;
            legacy_q <= legacy_d;
            zm_q     <= zero_mode;
            rm_q     <= rm_d;
            a_q      <= src_a;
            b_q      <= src_b;
            prev_q   <= dest_prev;
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        lane_issue = (state == ST_WAIT) ? act_q : '0;
        rm_out     = rm_q;
    end

    vdw_operand_route #(.LANE_W(LANE_W), .LANES(LANES)) u_route (
        .issue     (lane_issue),
        .bcast_use (bcast_q),
        .a_vec     (a_q),
        .b_vec     (b_q),
        .dividend  (lane_dividend),
        .divisor   (lane_divisor)
    );

    vdw_lane_collect #(.LANE_W(LANE_W), .LANES(LANES), .FLAG_W(FLAG_W)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .act        (act_q),
        .issue      (lane_issue),
        .quot_valid (quot_valid),
        .quot_data  (quot_data),
        .quot_flags (quot_flags),
        .q_held     (q_held),
        .f_held     (f_held),
        .all_in     (all_in)
    );

    vdw_dest_assemble #(.LANE_W(LANE_W), .LANES(LANES), .FLAG_W(FLAG_W)) u_assemble (
        .act       (act_q),
        .wr        (wr_q),
        .zero_mode (zm_q),
        .legacy    (legacy_q),
        .prev      (prev_q),
        .q_held    (q_held),
        .f_held    (f_held),
        .dest      (dest_c),
        .status    (status_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_out     <= '0;
            status_flags <= '0;
        end else if (state == ST_WAIT && all_in) begin
            dest_out     <= dest_c;
            status_flags <= status_c;
        end
    end

    // R10: completion lasts a single cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: issued lane set is held for the whole wait
    a_r1_issue_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && $past(state == ST_WAIT)) |-> $stable(lane_issue));

    // R8: rounding mode fixed while busy
    a_r8_rm_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rm_out));

    // R6: newer encodings at 128 bits clear the upper part
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !legacy_q && !act_q[2]) |-> (dest_out[VEC_W-1:LOW_W] == '0));

    // R9: nothing written means no flags
    a_r9_quiet_status: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_q == '0) |-> (status_flags == '0));
endmodule

// File: tb/vdiv_wb_ctrl_tb.sv
module vdiv_wb_ctrl_tb;
    localparam int LW = 64;
    localparam int NL = 8;
    localparam int FW = 6;
    localparam int VW = LW * NL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 0;
    logic [1:0]    enc_class = 0, len_sel = 0;
    logic [VW-1:0] src_a = '0, src_b = '0, dest_prev = '0;
    logic [NL-1:0] lane_mask = '0;
    logic          mask_en = 0, zero_mode = 0, bcast = 0, b_is_mem = 0;
    logic [1:0]    embed_rm = 0, global_rm = 0;
    logic [NL-1:0] quot_valid = '0;
    logic [VW-1:0] quot_data = '0;
    logic [FW*NL-1:0] quot_flags = '0;
    logic          busy, done;
    logic [NL-1:0] lane_issue;
    logic [VW-1:0] lane_dividend, lane_divisor, dest_out;
    logic [1:0]    rm_out;
    logic [FW-1:0] status_flags;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    vdiv_wb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .enc_class(enc_class), .len_sel(len_sel),
        .src_a(src_a), .src_b(src_b), .dest_prev(dest_prev), .lane_mask(lane_mask),
        .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast), .b_is_mem(b_is_mem),
        .embed_rm(embed_rm), .global_rm(global_rm), .quot_valid(quot_valid),
        .quot_data(quot_data), .quot_flags(quot_flags), .busy(busy),
        .lane_issue(lane_issue), .lane_dividend(lane_dividend), .lane_divisor(lane_divisor),
        .rm_out(rm_out), .done(done), .dest_out(dest_out), .status_flags(status_flags)
    );

    function automatic logic [LW-1:0] qmodel(logic [LW-1:0] a, logic [LW-1:0] b);
        return (a ^ {b[31:0], b[63:32]}) + 64'd1;
    endfunction

    function automatic logic [VW-1:0] rvec();
        logic [VW-1:0] v;
        for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] e, logic [1:0] ln, logic [VW-1:0] a, logic [VW-1:0] b,
                          logic [VW-1:0] pv, logic [NL-1:0] m, logic me, logic zm,
                          logic bc, logic mem, logic [1:0] erm, logic [1:0] grm);
        logic [NL-1:0] e_act, e_wr;
        logic [VW-1:0] e_dest, e_dvd, e_dvs;
        logic [FW-1:0] e_stat;
        logic [FW-1:0] fl [NL];
        int dly [NL];
        int n, cyc;
        logic legacy, masked, use_bc;
        logic [1:0] e_rm;

        legacy = (e == 2'd0);
        masked = (e == 2'd2);
        n = legacy ? 2 : (ln == 2'd0 ? 2 : (ln == 2'd1 ? 4 : 8));
        use_bc = masked && bc && mem;
        e_rm = (masked && !legacy && ln[1] && bc && !mem) ? erm : grm;
        e_stat = '0;
        for (int j = 0; j < NL; j++) begin
            logic [LW-1:0] dv;
            e_act[j] = (j < n);
            e_wr[j]  = e_act[j] && (!masked || !me || m[j]);
            dv = use_bc ? b[LW-1:0] : b[j*LW +: LW];
            e_dvd[j*LW +: LW] = e_act[j] ? a[j*LW +: LW] : '0;
            e_dvs[j*LW +: LW] = e_act[j] ? dv : '0;
            fl[j] = FW'($urandom);
            dly[j] = int'($urandom % 6);
            if (!e_act[j])      e_dest[j*LW +: LW] = legacy ? pv[j*LW +: LW] : '0;
            else if (e_wr[j])   e_dest[j*LW +: LW] = qmodel(a[j*LW +: LW], dv);
            else if (zm)        e_dest[j*LW +: LW] = '0;
            else                e_dest[j*LW +: LW] = pv[j*LW +: LW];
            if (e_wr[j]) e_stat = e_stat | fl[j];
        end

        @(negedge clk);
        enc_class = e; len_sel = ln; src_a = a; src_b = b; dest_prev = pv;
        lane_mask = m; mask_en = me; zero_mode = zm; bcast = bc; b_is_mem = mem;
        embed_rm = erm; global_rm = grm; start = 1;
        @(negedge clk);
        // R10: scramble inputs and keep start high during the operation
        src_a = ~a; src_b = rvec(); dest_prev = ~pv; lane_mask = ~m; zero_mode = ~zm;
        embed_rm = ~erm; global_rm = ~grm; bcast = ~bc;
        chk(lane_issue == e_act, "R1 lane_issue", VW'(lane_issue), VW'(e_act));
        chk(rm_out == e_rm, "R8 rm_out", VW'(rm_out), VW'(e_rm));
        chk(lane_dividend == e_dvd, "R2 dividend", lane_dividend, e_dvd);
        chk(lane_divisor == e_dvs, use_bc ? "R3 broadcast divisor" : "R2 divisor",
            lane_divisor, e_dvs);
        cyc = 0;
        while (!done && cyc < 60) begin
            for (int j = 0; j < NL; j++) begin
                if (lane_issue[j]) begin
                    if (cyc >= dly[j]) begin
                        quot_valid[j] = 1'b1;
                        quot_data[j*LW +: LW] = qmodel(lane_dividend[j*LW +: LW],
                                                       lane_divisor[j*LW +: LW]);
                        quot_flags[j*FW +: FW] = fl[j];
                    end
                end else begin
                    // R11: junk return on a lane that was not issued
                    quot_valid[j] = 1'b1;
                    quot_data[j*LW +: LW] = {$urandom, $urandom};
                    quot_flags[j*FW +: FW] = '1;
                end
            end
            @(negedge clk);
            cyc++;
        end
        start = 0;
        quot_valid = '0;
        chk(done == 1'b1, "R10 done seen", VW'(done), VW'(1));
        chk(dest_out == e_dest, legacy ? "R7 legacy dest" :
            (masked ? "R4 R5 R6 masked dest" : "R6 dest"), dest_out, e_dest);
        chk(status_flags == e_stat, "R9 status", VW'(status_flags), VW'(e_stat));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 single pulse", VW'({done, busy}), VW'(0));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && lane_issue == 0, "R10 reset idle",
            VW'({busy, done, lane_issue}), VW'(0));
        chk(dest_out == '0 && status_flags == '0, "R9 reset outputs", dest_out, '0);
        rst_n = 1;
        @(negedge clk);
        // legacy with 512 requested: forced to 128, upper kept (R7)
        run_op(2'd0, 2'd2, rvec(), rvec(), rvec(), 8'h00, 1, 1, 1, 1, 2'd3, 2'd1);
        // three-operand 256: mask ignored (R4), upper cleared (R6)
        run_op(2'd1, 2'd1, rvec(), rvec(), rvec(), 8'h00, 1, 1, 1, 1, 2'd2, 2'd0);
        // masked 512 broadcast from register: rounding override (R8)
        run_op(2'd2, 2'd2, rvec(), rvec(), rvec(), 8'hA5, 1, 0, 1, 0, 2'd2, 2'd1);
        // masked 512 broadcast from memory (R3), zero mode (R5)
        run_op(2'd2, 2'd3, rvec(), rvec(), rvec(), 8'h3C, 1, 1, 1, 1, 2'd3, 2'd0);
        // masked, all mask clear, merge: nothing written (R5, R9)
        run_op(2'd2, 2'd1, rvec(), rvec(), rvec(), 8'h00, 1, 0, 0, 0, 2'd1, 2'd2);
        // masked, mask disabled (R4)
        run_op(2'd2, 2'd0, rvec(), rvec(), rvec(), 8'h00, 0, 1, 0, 1, 2'd1, 2'd3);
        for (int t = 0; t < 60; t++) begin
            run_op(2'($urandom), 2'($urandom), rvec(), rvec(), rvec(), 8'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   2'($urandom), 2'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule